// File: doc/BRIEF.md
# Bus-Programmed Sweep Scaling Attenuator

This block scales a sampled sweep ramp by a programmable fraction and can flip its sign. A host writes a 10-bit scaling code and a polarity bit through a byte-wide bus that has an address, a data byte and a data-valid strobe. Each incoming signed sample leaves the block two cycles later as `sample * code / 1024`, rounded toward negative infinity. In inverting mode the scaled value is also negated.

The code is split over two byte registers. The low register takes the eight low code bits. The high register takes the two top code bits, the polarity bit and five auxiliary control bits. A write is captured when the data-valid strobe falls, using the address and data that were present while the strobe was high. The scaling path keeps using its previous factor until the high register is written. At that point the code and polarity change together, so a half-programmed factor never reaches the output.

Top module: `sweep_atten`

## Requirements
- R1: After reset, `smp_valid_o` is 0, `smp_data_o` is 0 and `aux_o` is 0. The applied factor is code 0 in inverting mode, so every sample gives 0.
- R2: A write to address 75 stores data bits [7:0] as code bits [7:0]. On its own it does not change the factor applied to samples.
- R3: A write to address 76 applies the new factor. Code bits [9:8] come from data bits [1:0], code bits [7:0] come from the stored low register, and the polarity comes from data bit 2. The code and polarity take effect together.
- R4: A write happens only on a high-to-low transition of `bus_valid_i`, using the address and data present while it was high. Holding the strobe high or low writes nothing.
- R5: A write to any address other than 75 or 76 changes neither the applied factor nor `aux_o`.
- R6: With polarity bit 1, the output is floor(x * code / 1024) for a 16-bit two's-complement input x.
- R7: With polarity bit 0, the output is the negation of floor(x * code / 1024). The output is clamped to the 16-bit signed range, so it never equals -32768.
- R8: Each sample presented with `smp_valid_i` high appears two clock cycles later with `smp_valid_o` high. Back-to-back samples keep their order. `smp_valid_o` is low two cycles after a cycle in which `smp_valid_i` is low.
- R9: `aux_o` takes data bits [7:3] of the most recent write to address 76.
- R10: Code 1023 scales by 1023/1024. For example, 16384 gives 16368 and -32768 gives -32736.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by the bus and the samples |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Register address |
| bus_data_i | input | 8 | Write data byte |
| bus_valid_i | input | 1 | Data-valid strobe; the write happens when it falls |
| smp_valid_i | input | 1 | Input sample valid |
| smp_data_i | input | 16 | Input sample, two's complement |
| smp_valid_o | output | 1 | Output sample valid |
| smp_data_o | output | 16 | Scaled output sample |
| aux_o | output | 5 | Auxiliary control bits from the high register |

## Verification
The bench writes only the low register and checks that samples still use the old factor. A design that applied each byte as it arrived would output a mixed factor there. The strobe is held high for several cycles with a valid high-register write pending, and the factor must not change until the strobe drops; a design that captured on the rising edge or on level would fail that check. Negative inputs with small codes test rounding toward negative infinity, where a design that truncates toward zero would give 0 instead of -1. Full-scale code with the most negative input and inversion tests the widest products and the sign path, which would expose a product register that is too narrow or a missing sign extension.

// File: rtl/sweep_atten_pkg.sv
package sweep_atten_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/sweep_atten_regs.sv
module sweep_atten_regs
  import sweep_atten_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int CW      = 10,
  parameter int ADDR_LO = 75,
  parameter int ADDR_HI = 76,
  localparam int HW     = CW - DW,
  localparam int POL_B  = HW,
  localparam int XW     = DW - HW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_valid_i,
  output logic [CW-1:0] code_o,
  output logic          pol_o,
  output logic [XW-1:0] aux_o,
  output logic          wr_hi_o,
  output logic          wr_any_o
);
  logic          stb_q1, stb_q2;
  logic [AW-1:0] addr_h;
  logic [DW-1:0] data_h;
  logic [DW-1:0] lo_q;
  logic          fall;
  reg_sel_e      sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q1 <= 1'b0;
      stb_q2 <= 1'b0;
      addr_h <= '0;
      data_h <= '0;
    end else begin
      stb_q1 <= bus_valid_i;
      stb_q2 <= stb_q1;
      if (bus_valid_i) begin
        addr_h <= bus_addr_i;
        data_h <= bus_data_i;
      end
    end
  end

  assign fall = stb_q2 & ~stb_q1;

  always_comb begin
    sel = SEL_NONE;
    if (fall) begin
      if (addr_h == AW'(ADDR_LO))      sel = SEL_LO;
      else if (addr_h == AW'(ADDR_HI)) sel = SEL_HI;
    end
  end

  assign wr_hi_o  = (sel == SEL_HI);
  assign wr_any_o = fall;

  // applied factor only moves on the high write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      code_o <= '0;
      pol_o  <= 1'b0;
      aux_o  <= '0;
    end else begin
      case (sel)
        SEL_LO: lo_q <= data_h;
        SEL_HI: begin
          code_o <= {data_h[HW-1:0], lo_q};
          pol_o  <= data_h[POL_B];
          aux_o  <= data_h[DW-1:POL_B+1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sweep_atten_scale.sv
module sweep_atten_scale #(
  parameter int IW   = 16,
  parameter int CW   = 10,
  localparam int PW  = IW + CW + 1,
  localparam int EW  = IW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CW-1:0]        code_i,
  input  logic                 pol_i,
  input  logic                 vld_i,
  input  logic signed [IW-1:0] x_i,
  output logic                 vld_o,
  output logic signed [IW-1:0] y_o
);
  localparam logic signed [EW-1:0] MAXV = EW'((1 <<< (IW-1)) - 1);
  localparam logic signed [EW-1:0] MINV = -EW'(1 <<< (IW-1));

  logic signed [PW-1:0] prod_q;
  logic                 pol_q, vld_q;
  logic signed [PW-1:0] shifted;
  logic signed [EW-1:0] ext, sel;
  logic signed [IW-1:0] sat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
      pol_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q  <= vld_i;
      pol_q  <= pol_i;
      prod_q <= PW'(x_i) * $signed({1'b0, code_i});
    end
  end

  // arithmetic shift floors toward -inf
  assign shifted = prod_q >>> CW;
  assign ext     = shifted[EW-1:0];
  assign sel     = pol_q ? ext : -ext;

  always_comb begin
    if (sel > MAXV)      sat = MAXV[IW-1:0];
    else if (sel < MINV) sat = MINV[IW-1:0];
    else                 sat = sel[IW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      y_o   <= '0;
    end else begin
      vld_o <= vld_q;
      if (vld_q) y_o <= sat;
    end
  end
endmodule

// File: rtl/sweep_atten.sv
module sweep_atten #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int CW      = 10,
  parameter int IW      = 16,
  parameter int ADDR_LO = 75,
  parameter int ADDR_HI = 76,
  localparam int XW     = DW - (CW - DW) - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_valid_i,
  input  logic          smp_valid_i,
  input  logic [IW-1:0] smp_data_i,
  output logic          smp_valid_o,
  output logic [IW-1:0] smp_data_o,
  output logic [XW-1:0] aux_o
);
  logic [CW-1:0] act_code;
  logic          act_pol;
  logic          wr_hi, wr_any;
  logic signed [IW-1:0] y;

  sweep_atten_regs #(
    .AW(AW), .DW(DW), .CW(CW), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_addr_i (bus_addr_i),
    .bus_data_i (bus_data_i),
    .bus_valid_i(bus_valid_i),
    .code_o     (act_code),
    .pol_o      (act_pol),
    .aux_o      (aux_o),
    .wr_hi_o    (wr_hi),
    .wr_any_o   (wr_any)
  );

  sweep_atten_scale #(.IW(IW), .CW(CW)) u_scale (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .code_i(act_code),
    .pol_i (act_pol),
    .vld_i (smp_valid_i),
    .x_i   ($signed(smp_data_i)),
    .vld_o (smp_valid_o),
    .y_o   (y)
  );

  assign smp_data_o = y;
endmodule

// File: rtl/sweep_atten_chk.sv
module sweep_atten_chk #(
  parameter int CW = 10,
  parameter int IW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_valid_i,
  input logic          smp_valid_i,
  input logic          smp_valid_o,
  input logic [IW-1:0] smp_data_o,
  input logic          wr_hi,
  input logic          wr_any,
  input logic [CW-1:0] act_code,
  input logic          act_pol
);
  // R3
  factor_atomic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_hi) |-> $stable({act_code, act_pol}));

  // R4
  strobe_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |-> (!$past(bus_valid_i) && $past(bus_valid_i, 2)));

  // R7
  no_min_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> (smp_data_o != {1'b1, {(IW-1){1'b0}}}));

  // R8
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |-> ##2 smp_valid_o);

  // R8
  idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |-> ##2 !smp_valid_o);
endmodule

bind sweep_atten sweep_atten_chk #(.CW(CW), .IW(IW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_valid_i(bus_valid_i),
  .smp_valid_i(smp_valid_i),
  .smp_valid_o(smp_valid_o),
  .smp_data_o (smp_data_o),
  .wr_hi      (wr_hi),
  .wr_any     (wr_any),
  .act_code   (act_code),
  .act_pol    (act_pol)
);

// File: tb/tb_sweep_atten.sv
`timescale 1ns/1ps
module tb_sweep_atten;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [7:0]  bus_data_i = '0;
  logic        bus_valid_i = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_data_i = '0;
  logic        smp_valid_o;
  logic [15:0] smp_data_o;
  logic [4:0]  aux_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  sweep_atten dut (.*);

  function automatic int expv(int x, int code, bit pol);
    longint p = longint'(x) * longint'(code);
    longint s = p >>> 10;
    if (!pol) s = -s;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(int a, int d);
    @(negedge clk_i);
    bus_addr_i = 8'(a); bus_data_i = 8'(d); bus_valid_i = 1'b1;
    repeat (2) @(negedge clk_i);
    bus_valid_i = 1'b0;
    bus_addr_i = 8'hAA; bus_data_i = 8'h55;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic sample(string req, int x, int exp);
    @(negedge clk_i);
    smp_valid_i = 1'b1; smp_data_i = 16'(x);
    @(negedge clk_i);
    smp_valid_i = 1'b0; smp_data_i = 16'h1234;
    @(negedge clk_i);
    chk(req, int'(smp_valid_o), 1);
    chk(req, int'($signed(smp_data_o)), exp);
    @(negedge clk_i);
    chk(req, int'(smp_valid_o), 0);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1", int'(smp_valid_o), 0);
    chk("R1", int'(smp_data_o), 0);
    chk("R1", int'(aux_o), 0);
    sample("R1", 1000, 0);
  endtask

  task automatic t_full_scale;
    bus_write(75, 8'hFF);
    bus_write(76, 8'h04 | 8'h03);
    sample("R10", 16384, 16368);
    sample("R10", -32768, -32736);
    chk("R9", int'(aux_o), 0);
  endtask

  task automatic t_half_write;
    bus_write(75, 8'h00);
    sample("R2", 16384, expv(16384, 1023, 1));
    bus_write(76, 8'h02);      // code 512, inverting
    sample("R3", 1000, expv(1000, 512, 0));
    sample("R7", -3, expv(-3, 512, 0));
  endtask

  task automatic t_floor;
    bus_write(75, 8'h01);
    bus_write(76, 8'h04);      // code 1, non-inverting
    sample("R6", -1, -1);
    sample("R6", 1023, 0);
    sample("R6", 30000, expv(30000, 1, 1));
  endtask

  task automatic t_strobe_hold;
    @(negedge clk_i);
    bus_addr_i = 8'd76; bus_data_i = 8'hFF; bus_valid_i = 1'b1;
    repeat (6) @(negedge clk_i);
    sample("R4", 1024, 1);
    chk("R4", int'(aux_o), 0);
    bus_valid_i = 1'b0;
    repeat (4) @(negedge clk_i);
    sample("R4", 1024, expv(1024, 769, 1));
    chk("R9", int'(aux_o), 5'h1F);
    repeat (6) @(negedge clk_i);   // strobe stays low
    sample("R4", 1024, expv(1024, 769, 1));
  endtask

  task automatic t_ignore;
    bus_write(77, 8'h00);
    bus_write(74, 8'h00);
    bus_write(0, 8'h00);
    bus_write(255, 8'h00);
    sample("R5", 1024, expv(1024, 769, 1));
    chk("R5", int'(aux_o), 5'h1F);
  endtask

  task automatic t_invert_full;
    bus_write(75, 8'hFF);
    bus_write(76, 8'h03 | 8'h50);  // code 1023, inverting, aux 0x0A
    sample("R7", -32768, 32736);
    sample("R7", 32767, expv(32767, 1023, 0));
    chk("R9", int'(aux_o), 5'h0A);
  endtask

  task automatic t_stream;
    int xs[3] = '{100, -2000, 32000};
    @(negedge clk_i);
    for (int i = 0; i < 3; i++) begin
      smp_valid_i = 1'b1; smp_data_i = 16'(xs[i]);
      @(negedge clk_i);
      if (i >= 1) begin
        chk("R8", int'(smp_valid_o), 1);
        chk("R8", int'($signed(smp_data_o)), expv(xs[i-1], 1023, 0));
      end
    end
    smp_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R8", int'(smp_valid_o), 1);
    chk("R8", int'($signed(smp_data_o)), expv(xs[2], 1023, 0));
    @(negedge clk_i);
    chk("R8", int'(smp_valid_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_full_scale();
    t_half_write();
    t_floor();
    t_strobe_hold();
    t_ignore();
    t_invert_full();
    t_stream();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule